// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block is the programming face of an interrupt router. Software reaches every internal register through two bus windows. A write to the select window picks an internal index. Accesses to the data window then read or write the register at that index. The block holds an identification word, a fixed version word and a read-only arbitration word. It also holds a redirection table with a low and a high 32-bit word for each of 24 interrupt pins.

From the table the block derives two values for each pin and drives them on ports for the delivery logic next to it. One is an 8-bit vector. The other is a 32-bit destination, in which the value 0xFF widens to an all-ones broadcast. A bus access at any offset other than the two windows is refused with an error flag and changes nothing.

The bus takes a single-cycle request. The response (valid, error, read data) is registered and appears on the cycle after the request.

Top module: `irq_route_regfile`

## Requirements
- R1: An access whose 20-bit offset is neither 0x00 nor 0x10 returns a response with the error flag set. Read data for such an access is 0xFFFFFFFF. The select value, all stored words and all pin exports stay unchanged.
- R2: A write at offset 0x00 loads all 32 bits of the written data into the select register. A read at offset 0x00 returns the select value.
- R3: With select equal to 0, the data window at offset 0x10 reads and writes the 32-bit identification word.
- R4: With select equal to 1, a data-window read returns 0x00170011. Writes at this index leave that value unchanged.
- R5: With select equal to 2, a data-window read returns the arbitration word, which is zero after reset. Writes at this index are ignored.
- R6: Selects 3 through 0x0F read zero through the data window, and writes at these selects are ignored.
- R7: For pin n (0 to 23), select 0x10+2n holds the pin's low word and select 0x11+2n holds its high word. Each word stores and reads back all 32 written bits.
- R8: A data-window read with a select of 0x40 or above returns 0xFFFFFFFF. A write at such a select changes no stored word and no export.
- R9: Pin n's vector is driven on `pin_vector[8n+7:8n]`. It takes bits 7:0 of a write to the pin's low word only when that byte is nonzero. A zero byte leaves the vector as it was, although the word itself is still stored.
- R10: Pin n's destination is driven on `pin_dest[32n+31:32n]`. A write to the pin's high word whose bits 31:24 equal 0xFF sets it to 0xFFFFFFFF. Any other value of those bits sets it to that byte zero-extended.
- R11: Every request produces exactly one response, with `rsp_valid` high on the following cycle, and no response occurs without a request. For a valid offset `rsp_err` is low. A write response carries zero data.
- R12: After reset the select, identification and arbitration words, all table words and all pin exports are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_offset | input | 20 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Response marks an invalid offset |
| rsp_rdata | output | 32 | Read data of the response |
| pin_vector | output | 192 | Per-pin 8-bit vectors, pin n at bits 8n+7:8n |
| pin_dest | output | 768 | Per-pin 32-bit destinations, pin n at bits 32n+31:32n |

## Verification
All 24 pins are programmed with distinct vector and destination bytes. A mistake in the index-to-pin mapping therefore shows up on the wrong export slice, and the read-back of every word separates the low word from the high word. One pin is then swept over all 256 destination bytes, which tells the broadcast widening apart from plain zero-extension. Zero-vector writes show that the stored word and the exported vector can differ. A full read sweep of selects 0 through 0x4F, plus the extreme select 0xFFFFFFFF, covers the fixed registers, the reserved gap, the table and the out-of-range region. A set of stray offsets checks that refused accesses report an error and alter neither the select nor any export.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int OFS_INDEX    = 'h00;
    localparam int OFS_DATA     = 'h10;
    localparam int IDX_ID       = 0;
    localparam int IDX_VER      = 1;
    localparam int IDX_ARB      = 2;
    localparam int TABLE_BASE   = 'h10;
    localparam int VEC_W        = 8;
    localparam int DEST_BYTE_W  = 8;
    localparam logic [31:0] VERSION_VALUE = 32'h0017_0011;

    typedef enum logic [1:0] {
        WIN_INDEX = 2'd0,
        WIN_DATA  = 2'd1,
        WIN_BAD   = 2'd2
    } win_e;

endpackage

// File: rtl/irr_window_decode.sv
module irr_window_decode
    import irr_pkg::*;
#(
    parameter int OFS_W = 20
) (
    input  logic [OFS_W-1:0] offset,
    output win_e             win
);

    always_comb begin
        if (offset == OFS_W'(OFS_INDEX)) begin
            win = WIN_INDEX;
        end else if (offset == OFS_W'(OFS_DATA)) begin
            win = WIN_DATA;
        end else begin
            win = WIN_BAD;
        end
    end

endmodule

// File: rtl/irr_pin_export.sv
module irr_pin_export
    import irr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [VEC_W-1:0]  vector,
    output logic [DATA_W-1:0] dest
);

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [DATA_W-1:0] dst;
    } pin_t;

    pin_t p_d, p_q;
    logic [DEST_BYTE_W-1:0] dbyte;

    assign dbyte = wdata[DATA_W-1 -: DEST_BYTE_W];

    always_comb begin
        p_d = p_q;
        if (lo_we && (wdata[VEC_W-1:0] != '0)) begin
            p_d.vec = wdata[VEC_W-1:0];
        end
        if (hi_we) begin
            p_d.dst = (dbyte == '1) ? '1 : DATA_W'(dbyte);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign vector = p_q.vec;
    assign dest   = p_q.dst;

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int OFS_W    = 20,
    parameter int DATA_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [OFS_W-1:0]          req_offset,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [NUM_PINS*VEC_W-1:0] pin_vector,
    output logic [NUM_PINS*DATA_W-1:0] pin_dest
);

    localparam int WORDS   = 2 * NUM_PINS;
    localparam int TIDX_W  = $clog2(WORDS);
    localparam int IDX_END = TABLE_BASE + WORDS;

    typedef struct packed {
        logic [DATA_W-1:0]            sel;
        logic [DATA_W-1:0]            id;
        logic [DATA_W-1:0]            arb;
        logic [WORDS-1:0][DATA_W-1:0] tbl;
        logic                         rsp_v;
        logic                         rsp_e;
        logic [DATA_W-1:0]            rsp_d;
    } state_t;

    state_t s_d, s_q;
    win_e   win;

    logic              in_table;
    logic [TIDX_W-1:0] tword;
    logic [DATA_W-1:0] rd_word;
    logic              data_wr;

    irr_window_decode #(.OFS_W(OFS_W)) u_decode (
        .offset (req_offset),
        .win    (win)
    );

    assign in_table = (s_q.sel >= DATA_W'(TABLE_BASE)) && (s_q.sel < DATA_W'(IDX_END));
    assign tword    = TIDX_W'(s_q.sel - DATA_W'(TABLE_BASE));
    assign data_wr  = req_valid && req_write && (win == WIN_DATA);

    // Data-window read mux, selected by the held index.
    always_comb begin
        if (s_q.sel == DATA_W'(IDX_ID)) begin
            rd_word = s_q.id;
        end else if (s_q.sel == DATA_W'(IDX_VER)) begin
            rd_word = DATA_W'(VERSION_VALUE);
        end else if (s_q.sel == DATA_W'(IDX_ARB)) begin
            rd_word = s_q.arb;
        end else if (s_q.sel < DATA_W'(TABLE_BASE)) begin
            rd_word = '0;
        end else if (in_table) begin
            rd_word = s_q.tbl[tword];
        end else begin
            rd_word = '1;
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = req_valid;
        s_d.rsp_e = 1'b0;
        s_d.rsp_d = '0;
        if (req_valid) begin
            case (win)
                WIN_INDEX: begin
                    if (req_write) begin
                        s_d.sel = req_wdata;
                    end else begin
                        s_d.rsp_d = s_q.sel;
                    end
                end
                WIN_DATA: begin
                    if (req_write) begin
                        if (s_q.sel == DATA_W'(IDX_ID)) begin
                            s_d.id = req_wdata;
                        end else if (in_table) begin
                            s_d.tbl[tword] = req_wdata;
                        end
                    end else begin
                        s_d.rsp_d = rd_word;
                    end
                end
                default: begin
                    s_d.rsp_e = 1'b1;
                    s_d.rsp_d = req_write ? '0 : '1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    genvar n;
    generate
        for (n = 0; n < NUM_PINS; n++) begin : g_pin
            logic lo_we, hi_we;
            assign lo_we = data_wr && (s_q.sel == DATA_W'(TABLE_BASE + 2 * n));
            assign hi_we = data_wr && (s_q.sel == DATA_W'(TABLE_BASE + 2 * n + 1));
            irr_pin_export #(.DATA_W(DATA_W)) u_pin (
                .clk    (clk),
                .rst_n  (rst_n),
                .lo_we  (lo_we),
                .hi_we  (hi_we),
                .wdata  (req_wdata),
                .vector (pin_vector[n*VEC_W +: VEC_W]),
                .dest   (pin_dest[n*DATA_W +: DATA_W])
            );
        end
    endgenerate

    assign rsp_valid = s_q.rsp_v;
    assign rsp_err   = s_q.rsp_e;
    assign rsp_rdata = s_q.rsp_d;

endmodule

// File: rtl/irr_route_checker.sv
module irr_route_checker
    import irr_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int OFS_W    = 20,
    parameter int DATA_W   = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [OFS_W-1:0]           req_offset,
    input logic                       rsp_valid,
    input logic                       rsp_err,
    input logic [DATA_W-1:0]          rsp_rdata,
    input logic [NUM_PINS*VEC_W-1:0]  pin_vector,
    input logic [NUM_PINS*DATA_W-1:0] pin_dest
);

    logic stray;
    assign stray = (req_offset != OFS_W'(OFS_INDEX)) && (req_offset != OFS_W'(OFS_DATA));

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11

    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11

    AST_ERR_ONLY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R11

    AST_STRAY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && stray) |=> rsp_err); // R1

    AST_GOOD_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stray) |=> !rsp_err); // R1

    AST_STRAY_NO_EXPORT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && stray) |=> ($stable(pin_vector) && $stable(pin_dest))); // R1

    AST_READ_NEVER_CHANGES_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> ($stable(pin_vector) && $stable(pin_dest))); // R9

    AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0)); // R11

    genvar n;
    generate
        for (n = 0; n < NUM_PINS; n++) begin : g_chk
            AST_DEST_FORM: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_dest[n*DATA_W +: DATA_W] == '1) ||
                (pin_dest[n*DATA_W + DEST_BYTE_W +: DATA_W - DEST_BYTE_W] == '0)); // R10

            AST_VEC_STAYS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(pin_vector[n*VEC_W +: VEC_W]) != '0) |->
                (pin_vector[n*VEC_W +: VEC_W] != '0)); // R9
        end
    endgenerate

endmodule

bind irq_route_regfile irr_route_checker #(
    .NUM_PINS (NUM_PINS),
    .OFS_W    (OFS_W),
    .DATA_W   (DATA_W)
) u_irr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_offset (req_offset),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .pin_vector (pin_vector),
    .pin_dest   (pin_dest)
);

// File: tb/test_irq_route_regfile.sv
`timescale 1ns/1ps
module test_irq_route_regfile;

    localparam int NP = 24;
    localparam int OW = 20;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [OW-1:0]     req_offset = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [DW-1:0]     rsp_rdata;
    logic [NP*8-1:0]   pin_vector;
    logic [NP*DW-1:0]  pin_dest;

    always #2.5 clk = ~clk;

    irq_route_regfile #(.NUM_PINS(NP), .OFS_W(OW), .DATA_W(DW)) i_irq_route_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .pin_vector (pin_vector),
        .pin_dest   (pin_dest)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model of the register contents.
    logic [31:0] m_sel = '0;
    logic [31:0] m_id  = '0;
    logic [31:0] m_tbl [2*NP];
    logic [7:0]  m_vec [NP];
    logic [31:0] m_dst [NP];

    logic        r_v, r_e;
    logic [31:0] r_d;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [OW-1:0] ofs, input logic [31:0] d);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = w;
        req_offset = ofs;
        req_wdata  = d;
        @(negedge clk);
        req_valid  = 1'b0;
        req_write  = 1'b0;
        r_v = rsp_valid;
        r_e = rsp_err;
        r_d = rsp_rdata;
    endtask

    function automatic logic [31:0] widen(input logic [7:0] b);
        return (b == 8'hFF) ? 32'hFFFF_FFFF : {24'h0, b};
    endfunction

    function automatic logic [31:0] model_read(input logic [31:0] idx);
        if (idx == 0)        return m_id;
        else if (idx == 1)   return 32'h0017_0011;
        else if (idx == 2)   return 32'h0;
        else if (idx < 16)   return 32'h0;
        else if (idx < 64)   return m_tbl[idx - 16];
        else                 return 32'hFFFF_FFFF;
    endfunction

    // Good-offset write with model update and R11 response check.
    task automatic wr(input logic [OW-1:0] ofs, input logic [31:0] d);
        access(1'b1, ofs, d);
        check("R11 write rsp_valid", {31'h0, r_v}, 32'h1);
        check("R11 write rsp_err", {31'h0, r_e}, 32'h0);
        check("R11 write data", r_d, 32'h0);
        if (ofs == 0) begin
            m_sel = d;
        end else begin
            if (m_sel == 0) m_id = d;
            else if (m_sel >= 16 && m_sel < 64) begin
                m_tbl[m_sel - 16] = d;
                if (m_sel[0] == 1'b0 && d[7:0] != 8'h0) m_vec[(m_sel - 16) / 2] = d[7:0];
                if (m_sel[0] == 1'b1) m_dst[(m_sel - 17) / 2] = widen(d[31:24]);
            end
        end
    endtask

    task automatic rd(input logic [OW-1:0] ofs);
        access(1'b0, ofs, 32'h0);
    endtask

    task automatic check_exports(input string req);
        for (int p = 0; p < NP; p++) begin
            check(req, {24'h0, pin_vector[p*8 +: 8]}, {24'h0, m_vec[p]});
            check(req, pin_dest[p*DW +: DW], m_dst[p]);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2*NP; i++) m_tbl[i] = '0;
        for (int p = 0; p < NP; p++) begin
            m_vec[p] = '0;
            m_dst[p] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check_exports("R12 exports");
        rd(20'h0);
        check("R12 select", r_d, 32'h0);
        rd(20'h10);
        check("R12 id", r_d, 32'h0);
        check("R11 read rsp_valid", {31'h0, r_v}, 32'h1);
        @(negedge clk);
        check("R11 no rsp when idle", {31'h0, rsp_valid}, 32'h0);

        // R2: select register
        wr(20'h0, 32'h1234_5678);
        rd(20'h0);
        check("R2 select readback", r_d, 32'h1234_5678);

        // R3: identification word
        wr(20'h0, 32'h0);
        wr(20'h10, 32'hDEAD_BEEF);
        rd(20'h10);
        check("R3 id readback", r_d, 32'hDEAD_BEEF);

        // R4: version constant
        wr(20'h0, 32'h1);
        rd(20'h10);
        check("R4 version", r_d, 32'h0017_0011);
        wr(20'h10, 32'h0);
        rd(20'h10);
        check("R4 version after write", r_d, 32'h0017_0011);

        // R5: arbitration word
        wr(20'h0, 32'h2);
        rd(20'h10);
        check("R5 arb", r_d, 32'h0);
        wr(20'h10, 32'hFFFF_FFFF);
        rd(20'h10);
        check("R5 arb after write", r_d, 32'h0);

        // R6: reserved selects
        for (int i = 3; i < 16; i++) begin
            wr(20'h0, i);
            wr(20'h10, 32'h0101_0101 * i);
            rd(20'h10);
            check("R6 reserved reads zero", r_d, 32'h0);
        end
        check_exports("R6 exports untouched");

        // R7, R9, R10: program every pin with distinct values
        for (int p = 0; p < NP; p++) begin
            logic [7:0] vb, db;
            vb = 8'((p * 11) + 1);
            db = (p == 5) ? 8'hFF : 8'(p * 9);
            wr(20'h0, 32'(16 + 2*p));
            wr(20'h10, {8'hA5, 8'(p), 8'h3C, vb});
            wr(20'h0, 32'(17 + 2*p));
            wr(20'h10, {db, 8'(p), 16'h5AC3});
            check("R9 vector export", {24'h0, pin_vector[p*8 +: 8]}, {24'h0, vb});
            check("R10 dest export", pin_dest[p*DW +: DW], widen(db));
        end
        check_exports("R7 all exports");
        for (int p = 0; p < NP; p++) begin
            wr(20'h0, 32'(16 + 2*p));
            rd(20'h10);
            check("R7 low word", r_d, m_tbl[2*p]);
            wr(20'h0, 32'(17 + 2*p));
            rd(20'h10);
            check("R7 high word", r_d, m_tbl[2*p+1]);
        end

        // R9: zero vector byte stores the word but keeps the vector
        for (int p = 0; p < NP; p += 3) begin
            wr(20'h0, 32'(16 + 2*p));
            wr(20'h10, 32'h7700_EE00);
            rd(20'h10);
            check("R9 word stored", r_d, 32'h7700_EE00);
            check("R9 vector kept", {24'h0, pin_vector[p*8 +: 8]}, {24'h0, m_vec[p]});
        end

        // R10: exhaustive destination byte sweep on the last pin
        wr(20'h0, 32'(17 + 2*(NP-1)));
        for (int b = 0; b < 256; b++) begin
            wr(20'h10, {8'(b), 24'h0005A5});
            check("R10 dest sweep", pin_dest[(NP-1)*DW +: DW], widen(8'(b)));
        end

        // R8: out-of-range selects
        wr(20'h0, 32'h40);
        rd(20'h10);
        check("R8 read at 0x40", r_d, 32'hFFFF_FFFF);
        wr(20'h10, 32'h1111_1111);
        wr(20'h0, 32'hFFFF_FFFF);
        rd(20'h10);
        check("R8 read at max select", r_d, 32'hFFFF_FFFF);
        wr(20'h10, 32'h2222_2222);
        check_exports("R8 exports untouched");
        for (int i = 0; i < 80; i++) begin
            wr(20'h0, i);
            rd(20'h10);
            check("R8 sweep read", r_d, model_read(i));
        end

        // R1: stray offsets
        wr(20'h0, 32'h0000_0020);
        for (int k = 0; k < 8; k++) begin
            logic [OW-1:0] bad;
            case (k)
                0: bad = 20'h00004;
                1: bad = 20'h00008;
                2: bad = 20'h0000C;
                3: bad = 20'h00011;
                4: bad = 20'h00020;
                5: bad = 20'h10000;
                6: bad = 20'h80010;
                default: bad = 20'hFFFFF;
            endcase
            access(1'b1, bad, 32'h0000_0003);
            check("R1 write error flag", {31'h0, r_e}, 32'h1);
            access(1'b0, bad, 32'h0);
            check("R1 read error flag", {31'h0, r_e}, 32'h1);
            check("R1 read data", r_d, 32'hFFFF_FFFF);
        end
        rd(20'h0);
        check("R1 select unchanged", r_d, 32'h0000_0020);
        rd(20'h10);
        check("R1 word unchanged", r_d, m_tbl[16]);
        check_exports("R1 exports unchanged");

        finish_run();
    end

endmodule